// File: doc/BRIEF.md
# Static Memory Read Strobe Sequencer

This block runs read cycles on an asynchronous external static memory. A requester presents an address and a two-bit chip-select index with `req_valid`. While `req_ready` is high the block takes the request, drives the address and holds it for the whole cycle. It then produces an active-low read strobe and one active-low chip select, and each has its own programmable setup and pulse width. Both windows sit inside one shared cycle whose length comes from a programmable total, stretched when needed. The block captures the 8-bit data returned by the memory and hands it back with a one-clock done pulse.

All timing is counted in clock periods from the first cycle in which the address is driven. A strobe is high during its setup count, low during its pulse count, and high again for the rest of the cycle, which is its hold time. Timing values are plain inputs and are latched when a request is accepted.

The controller has three states. **IDLE** accepts a request (transition *accept*, IDLE→RUN). **RUN** counts cycle positions and drives the strobes; it stays in RUN until the last position (*expire*, RUN→FINISH). **FINISH** presents the done pulse for one clock and then returns unconditionally (*release*, FINISH→IDLE).

Top module: `sram_read_timer`

## Requirements
- R1: After reset, `mem_rd_n` and all four `mem_cs_n` bits are high, `mem_addr` is zero, `req_ready` is high and `rsp_valid` is low.
- R2: A request is accepted only at a clock edge where `req_valid` and `req_ready` are both high. `mem_addr` shows the request address from the first cycle after acceptance and holds it until the done pulse. Requests presented while `req_ready` is low start nothing and do not change `mem_addr`.
- R3: Number the cycles after acceptance k = 0, 1, 2 and so on. `mem_rd_n` is low exactly for rd_setup <= k < rd_setup + rd_pulse.
- R4: The chip select `mem_cs_n[i]`, where i is the binary value of `req_cs` (0..3), is low exactly for cs_setup <= k < cs_setup + cs_pulse. The other three bits stay high.
- R5: A pulse setting of 0 behaves as a pulse of 1.
- R6: The cycle length is L = max(cycle, rd_setup + rd_pulse, cs_setup + cs_pulse), using effective pulses. `rsp_valid` is high for exactly one clock, at k = L, with all strobes high. `req_ready` returns at k = L + 1.
- R7: Read data is sampled at the clock edge that ends the earlier-ending of the two pulses, that is the edge closing cycle k = min(rd_end, cs_end) - 1. It is shown on `rsp_data` together with `rsp_valid`.
- R8: Timing inputs are latched at acceptance. Changing them during a cycle has no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 24 | Request address |
| req_cs | input | 2 | Chip-select index |
| req_ready | output | 1 | Engine idle, request can be taken |
| cfg_rd_setup | input | 6 | Read strobe setup, clocks |
| cfg_rd_pulse | input | 6 | Read strobe low width, clocks |
| cfg_cs_setup | input | 6 | Chip-select setup, clocks |
| cfg_cs_pulse | input | 6 | Chip-select low width, clocks |
| cfg_cycle | input | 6 | Total cycle length, clocks |
| mem_addr | output | 24 | Memory address bus |
| mem_cs_n | output | 4 | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_data_in | input | 8 | Memory read data |
| rsp_valid | output | 1 | Done pulse |
| rsp_data | output | 8 | Captured read data |

## Verification
Two functions can land in the same clock. Data capture and cycle expiry coincide when both pulses end on the last cycle position, and when all settings are zero the whole cycle is a single clock. The chip-select and read pulses can also close on the same edge. The vector table covers these settings. It also covers cases where the chip select closes before the read strobe, or closes while the read strobe has not yet fallen. The bench memory model returns a marker value whenever both strobes are not low together, so sampling one edge late shows up as a data mismatch, and the done position is compared against L computed in the bench.

// File: rtl/srt_pkg.sv
package srt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } srt_state_e;

    localparam int unsigned STROBE_RD = 0;
    localparam int unsigned STROBE_CS = 1;
    localparam int unsigned STROBE_N  = 2;
endpackage

// File: rtl/srt_window.sv
module srt_window #(
    parameter int unsigned CFG_W = 6,
    localparam int unsigned CNT_W = CFG_W + 1
) (
    input  logic [CNT_W-1:0] pos,
    input  logic [CFG_W-1:0] setup,
    input  logic [CFG_W-1:0] pulse,
    output logic             low,
    output logic [CNT_W-1:0] span
);
    logic [CNT_W-1:0] pulse_eff;

    always_comb begin
        // a zero width still gives one low period
        pulse_eff = (pulse == '0) ? CNT_W'(1) : {1'b0, pulse};
        span      = {1'b0, setup} + pulse_eff;
        low       = (pos >= {1'b0, setup}) && (pos < span);
    end
endmodule

// File: rtl/srt_cs_decode.sv
module srt_cs_decode #(
    parameter int unsigned LINES = 4,
    localparam int unsigned IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic [IDX_W-1:0] sel,
    input  logic             active,
    output logic [LINES-1:0] line_n
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        assign line_n[g] = !(active && (sel == IDX_W'(g)));
    end
endmodule

// File: rtl/sram_read_timer.sv
module sram_read_timer
    import srt_pkg::*;
#(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned CS_LINES = 4,
    parameter int unsigned CFG_W  = 6,
    localparam int unsigned IDX_W = (CS_LINES > 1) ? $clog2(CS_LINES) : 1,
    localparam int unsigned CNT_W = CFG_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [IDX_W-1:0]  req_cs,
    output logic              req_ready,
    input  logic [CFG_W-1:0]  cfg_rd_setup,
    input  logic [CFG_W-1:0]  cfg_rd_pulse,
    input  logic [CFG_W-1:0]  cfg_cs_setup,
    input  logic [CFG_W-1:0]  cfg_cs_pulse,
    input  logic [CFG_W-1:0]  cfg_cycle,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [CS_LINES-1:0] mem_cs_n,
    output logic              mem_rd_n,
    input  logic [DATA_W-1:0] mem_data_in,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    srt_state_e state_q, state_d;

    logic [CNT_W-1:0]  pos_q;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  sel_q;
    logic [CFG_W-1:0]  cyc_q;
    logic [DATA_W-1:0] data_q;
    logic [CFG_W-1:0]  win_setup_q [STROBE_N];
    logic [CFG_W-1:0]  win_pulse_q [STROBE_N];
    logic [STROBE_N-1:0] win_low;
    logic [CNT_W-1:0]  win_span [STROBE_N];

    logic [CNT_W-1:0] len;
    logic [CNT_W-1:0] first_end;
    logic             accept;
    logic             last_pos;
    logic             cs_active;

    for (genvar s = 0; s < STROBE_N; s++) begin : g_win
        srt_window #(.CFG_W(CFG_W)) u_win (
            .pos   (pos_q),
            .setup (win_setup_q[s]),
            .pulse (win_pulse_q[s]),
            .low   (win_low[s]),
            .span  (win_span[s])
        );
    end

    always_comb begin
        len = {1'b0, cyc_q};
        if (win_span[STROBE_RD] > len) len = win_span[STROBE_RD];
        if (win_span[STROBE_CS] > len) len = win_span[STROBE_CS];
        first_end = (win_span[STROBE_CS] < win_span[STROBE_RD])
                  ? win_span[STROBE_CS] : win_span[STROBE_RD];
        accept   = req_valid && (state_q == ST_IDLE);
        last_pos = (pos_q == len - CNT_W'(1));
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)   state_d = ST_RUN;     // accept
            ST_RUN:    if (last_pos) state_d = ST_FINISH;  // expire
            ST_FINISH:               state_d = ST_IDLE;    // release
            default:                 state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request latch, position counter and data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            addr_q <= '0;
            sel_q  <= '0;
            cyc_q  <= '0;
            data_q <= '0;
            for (int s = 0; s < STROBE_N; s++) begin
                win_setup_q[s] <= '0;
                win_pulse_q[s] <= '0;
            end
        end else begin
            if (accept) begin
                pos_q  <= '0;
                addr_q <= req_addr;
                sel_q  <= req_cs;
                cyc_q  <= cfg_cycle;
                win_setup_q[STROBE_RD] <= cfg_rd_setup;
                win_pulse_q[STROBE_RD] <= cfg_rd_pulse;
                win_setup_q[STROBE_CS] <= cfg_cs_setup;
                win_pulse_q[STROBE_CS] <= cfg_cs_pulse;
            end else if (state_q == ST_RUN) begin
                pos_q <= pos_q + CNT_W'(1);
                if (pos_q == first_end - CNT_W'(1)) data_q <= mem_data_in;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_FINISH);
        mem_rd_n  = !((state_q == ST_RUN) && win_low[STROBE_RD]);
        cs_active = (state_q == ST_RUN) && win_low[STROBE_CS];
        mem_addr  = addr_q;
        rsp_data  = data_q;
    end

    srt_cs_decode #(.LINES(CS_LINES)) u_dec (
        .sel    (sel_q),
        .active (cs_active),
        .line_n (mem_cs_n)
    );
endmodule

// File: rtl/srt_checker.sv
module srt_checker #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned CS_LINES = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [CS_LINES-1:0] mem_cs_n,
    input logic                mem_rd_n,
    input logic                rsp_valid
);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_rd_n && (&mem_cs_n)));

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

    p_single_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~mem_cs_n) <= 1);

    p_rd_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !req_ready);

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (mem_rd_n && (&mem_cs_n) && !req_ready));
endmodule

bind sram_read_timer srt_checker #(.ADDR_W(ADDR_W), .CS_LINES(CS_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_cs_n  (mem_cs_n),
    .mem_rd_n  (mem_rd_n),
    .rsp_valid (rsp_valid)
);

// File: tb/sram_read_timer_bench.sv
`timescale 1ns/1ps
module sram_read_timer_bench;
    typedef struct packed {
        logic [5:0]  rs;
        logic [5:0]  rp;
        logic [5:0]  cs;
        logic [5:0]  cp;
        logic [5:0]  cyc;
        logic [1:0]  sel;
        logic [23:0] addr;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{6'd1,  6'd3,  6'd0, 6'd5, 6'd6,  2'd0, 24'h123456},
        '{6'd2,  6'd2,  6'd1, 6'd2, 6'd4,  2'd1, 24'hABCDEF},
        '{6'd0,  6'd0,  6'd0, 6'd0, 6'd0,  2'd2, 24'h000001},
        '{6'd5,  6'd4,  6'd2, 6'd3, 6'd3,  2'd3, 24'hFFFFFF},
        '{6'd3,  6'd1,  6'd3, 6'd1, 6'd10, 2'd0, 24'h5A5A00},
        '{6'd0,  6'd7,  6'd2, 6'd2, 6'd8,  2'd2, 24'h0F0F33},
        '{6'd63, 6'd63, 6'd0, 6'd1, 6'd0,  2'd1, 24'h800080},
        '{6'd4,  6'd0,  6'd4, 6'd0, 6'd2,  2'd3, 24'h7E7E7E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic [1:0]  req_cs = '0;
    logic        req_ready;
    logic [5:0]  cfg_rd_setup = '0, cfg_rd_pulse = '0, cfg_cs_setup = '0;
    logic [5:0]  cfg_cs_pulse = '0, cfg_cycle = '0;
    logic [23:0] mem_addr;
    logic [3:0]  mem_cs_n;
    logic        mem_rd_n;
    logic [7:0]  mem_data_in;
    logic        rsp_valid;
    logic [7:0]  rsp_data;
    logic [1:0]  cur_sel = '0;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 0;

    always #10 clk = ~clk;

    // memory model: real data only while both strobes are low
    assign mem_data_in = (!mem_rd_n && !mem_cs_n[cur_sel]) ? (mem_addr[7:0] ^ 8'h5A) : 8'hEE;

    sram_read_timer u_sram_read_timer (
        .clk, .rst_n, .req_valid, .req_addr, .req_cs, .req_ready,
        .cfg_rd_setup, .cfg_rd_pulse, .cfg_cs_setup, .cfg_cs_pulse, .cfg_cycle,
        .mem_addr, .mem_cs_n, .mem_rd_n, .mem_data_in, .rsp_valid, .rsp_data
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        end
    endtask

    task automatic do_read(input vec_t v, input bit disturb);
        int rpe, cpe, rd_end, cs_end, len, smp, exp_data;
        int rd_first, rd_cnt, cs_first, cs_cnt, total, other_low, addr_bad;
        rpe = (v.rp == 0) ? 1 : int'(v.rp);
        cpe = (v.cp == 0) ? 1 : int'(v.cp);
        rd_end = int'(v.rs) + rpe;
        cs_end = int'(v.cs) + cpe;
        len = int'(v.cyc);
        if (rd_end > len) len = rd_end;
        if (cs_end > len) len = cs_end;
        smp = ((cs_end < rd_end) ? cs_end : rd_end) - 1;
        exp_data = ((smp >= int'(v.rs)) && (smp < rd_end) && (smp >= int'(v.cs)) && (smp < cs_end))
                 ? int'(v.addr[7:0] ^ 8'h5A) : 8'hEE;

        @(negedge clk);
        cur_sel = v.sel;
        req_valid = 1'b1; req_addr = v.addr; req_cs = v.sel;
        cfg_rd_setup = v.rs; cfg_rd_pulse = v.rp;
        cfg_cs_setup = v.cs; cfg_cs_pulse = v.cp; cfg_cycle = v.cyc;
        @(negedge clk);
        if (disturb) begin
            // R8 and R2: new settings and a new request while busy
            req_addr = ~v.addr; req_cs = v.sel + 2'd1;
            cfg_rd_setup = 6'd20; cfg_rd_pulse = 6'd20;
            cfg_cs_setup = 6'd20; cfg_cs_pulse = 6'd20; cfg_cycle = 6'd40;
        end else begin
            req_valid = 1'b0;
        end
        rd_first = -1; rd_cnt = 0; cs_first = -1; cs_cnt = 0;
        total = -1; other_low = 0; addr_bad = 0;
        for (int k = 0; k < 300; k++) begin
            if (rsp_valid) begin total = k; break; end
            if (!mem_rd_n) begin if (rd_first < 0) rd_first = k; rd_cnt++; end
            if (!mem_cs_n[v.sel]) begin if (cs_first < 0) cs_first = k; cs_cnt++; end
            for (int i = 0; i < 4; i++)
                if (i != int'(v.sel) && !mem_cs_n[i]) other_low = 1;
            if (mem_addr != v.addr) addr_bad = 1;
            @(negedge clk);
        end
        chk("R3 rd setup", rd_first, int'(v.rs));
        chk("R3 rd pulse R5", rd_cnt, rpe);
        chk("R4 cs setup", cs_first, int'(v.cs));
        chk("R4 cs pulse R5", cs_cnt, cpe);
        chk("R4 other lines high", other_low, 0);
        chk("R2 addr held", addr_bad, 0);
        chk("R6 length", total, len);
        chk("R7 data", int'(rsp_data), exp_data);
        chk("R6 busy during done", int'(req_ready), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R6 done single", int'(rsp_valid), 0);
        chk("R6 ready back", int'(req_ready), 1);
        if (disturb) begin
            repeat (2) @(negedge clk);
            chk("R2 no extra cycle", int'(mem_rd_n & (&mem_cs_n) & req_ready), 1);
            chk("R2 addr kept", int'(mem_addr == v.addr), 1);
        end
    endtask

    initial begin
        #(20ns * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, checked while reset is still asserted and just after release
        chk("R1 rd high", int'(mem_rd_n), 1);
        chk("R1 cs high", int'(mem_cs_n), 15);
        chk("R1 addr zero", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 no done", int'(rsp_valid), 0);

        for (int n = 0; n < NV; n++) do_read(VEC[n], 1'b0);

        // directed: disturbance during the cycle (R2, R8)
        do_read('{6'd1, 6'd2, 6'd0, 6'd3, 6'd5, 2'd2, 24'h3C3C3C}, 1'b1);
        do_read('{6'd0, 6'd0, 6'd2, 6'd0, 6'd0, 2'd1, 24'h00A5A5}, 1'b1);
        // directed: pulses end on the last position, capture and expiry coincide (R7, R6)
        do_read('{6'd2, 6'd3, 6'd4, 6'd1, 6'd5, 2'd0, 24'h112233}, 1'b0);

        summary();
        $finish;
    end
endmodule